// File: doc/BRIEF.md
# Five-bit to three-trit decoder

This block expands packed ternary weights into the two's-complement trit form that adders and multipliers consume directly. Every 5-bit code becomes three balanced ternary digits. Each digit is carried on two bits, so one code yields a 6-bit field. Packing three trits into 5 bits instead of 6 saves one sixth of the storage width. The decoder is placed on the read side of a weight memory and contains nothing but logic gates.

The 5-bit code is split into two parts. Its two low bits pick one of four magnitude groups, and each group fixes which digits are nonzero. The three high bits supply the digit signs, and they double as magnitudes wherever a group leaves a digit undetermined. A parameter sets the number of lanes, so a whole memory word that is a multiple of 5 bits wide can be expanded in one step. The logic has no clock, no state and no handshake.

Top module: `tern_word_expand`

## Requirements
- R1: Each digit is a two-bit pair whose low bit is the magnitude and whose high bit is the sign. The encodings are -1 = 11, 0 = 00 and +1 = 01. No input ever produces the pair 10.
- R2: Within a lane, output bits [5:4] hold the top digit, [3:2] the middle digit and [1:0] the low digit. Their signs come from code bits 4, 3 and 2 respectively. A zero digit always has sign bit 0.
- R3: When code bits [1:0] = 11, all three digits are nonzero.
- R4: When code bits [1:0] = 00, the top digit is zero, the middle digit is nonzero, and the low digit's magnitude equals code bit 4.
- R5: When code bits [1:0] = 10, the middle digit is zero, the low digit is nonzero, and the top digit's magnitude equals code bit 3.
- R6: When code bits [1:0] = 01, the low digit is zero, the middle digit's magnitude equals code bit 2, and the top digit's magnitude equals code bit 3 OR code bit 2.
- R7: The 32 codes reach all 27 digit triples. Exactly 5 triples are reached by two codes each.
- R8: Lane k decodes code bits [5k+4:5k] into output bits [6k+5:6k], independently of every other lane.
- R9: The output follows the input combinationally, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 5*LANES | Packed codes, 5 bits per lane, with lane 0 in the lowest bits |
| trit_o | output | 6*LANES | Decoded digit pairs, 6 bits per lane, with lane 0 in the lowest bits |

## Verification
The bench drives every one of the 32 codes through each lane and compares each lane with a behavioural model that works in signed integers.

- **Shared sign bit.** Codes in group 00 use bit 4 as a magnitude. A design that mixed up a sign source with a magnitude source would show up there as a wrong sign, or as an illegal 10 pair on a zero digit.
- **Lane wiring.** Lanes receive different codes in the same cycle. A lane offset or swap therefore shows up as a mismatch in a neighbouring field.
- **Reachability.** The decoded triples are tallied. A mapping that duplicated the wrong codes would miss a triple or change the duplicate count from five.

// File: rtl/tw_pkg.sv
// Package: shared widths and group encoding for the ternary word expander.
// Assumes the fixed ratio of 5 code bits to 3 digits of 2 bits each.
package tw_pkg;
    localparam int CODE_W  = 5;
    localparam int DIGITS  = 3;
    localparam int TRIT_W  = 2 * DIGITS;

    // Magnitude group selected by code bits [1:0].
    typedef enum logic [1:0] {
        GRP_TOP_ZERO = 2'b00,
        GRP_LOW_ZERO = 2'b01,
        GRP_MID_ZERO = 2'b10,
        GRP_ALL_SET  = 2'b11
    } mag_group_e;
endpackage

// File: rtl/tw_mag_select.sv
// Module: picks the three digit magnitudes for one 5-bit code.
// Assumes code[1:0] is the group selector and code[4:2] are reusable bits.
module tw_mag_select
    import tw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DIGITS-1:0] mag    // index 2 = top digit
);
    mag_group_e grp;

    assign grp = mag_group_e'(code[1:0]);

    // Purpose: map the selected group and spare bits onto a magnitude vector.
    always_comb begin
        case (grp)
            GRP_ALL_SET:  mag = 3'b111;
            GRP_TOP_ZERO: mag = {1'b0, 1'b1, code[4]};
            GRP_MID_ZERO: mag = {code[3], 1'b0, 1'b1};
            default:      mag = {code[3] | code[2], code[2], 1'b0};
        endcase
    end
endmodule

// File: rtl/tw_sign_merge.sv
// Module: builds the sign/magnitude pairs from magnitudes and sign bits.
// Assumes sign source j drives digit j; a zero magnitude forces a zero sign.
module tw_sign_merge
    import tw_pkg::*;
(
    input  logic [DIGITS-1:0] mag,
    input  logic [DIGITS-1:0] sgn_src,
    output logic [TRIT_W-1:0] pairs
);
    for (genvar j = 0; j < DIGITS; j++) begin : g_pair
        // Purpose: gate each sign with its magnitude so 10 cannot appear.
        always_comb begin
            pairs[2*j]   = mag[j];
            pairs[2*j+1] = mag[j] & sgn_src[j];
        end
    end
endmodule

// File: rtl/tw_lane.sv
// Module: one complete 5-bit to 3-digit decoder lane.
// Assumes a purely combinational path; the checks below watch the lane's ports.
module tw_lane
    import tw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [TRIT_W-1:0] trits
);
    logic [DIGITS-1:0] mag;

    tw_mag_select u_mag (
        .code (code),
        .mag  (mag)
    );

    tw_sign_merge u_sign (
        .mag     (mag),
        .sgn_src (code[4:2]),
        .pairs   (trits)
    );

    // Purpose: guard the lane's port-level contract on every input change.
    always_comb begin
        AST_NO_ILLEGAL_TOP: assert (trits[5:4] != 2'b10);                    // R1
        AST_NO_ILLEGAL_MID: assert (trits[3:2] != 2'b10);                    // R1
        AST_NO_ILLEGAL_LOW: assert (trits[1:0] != 2'b10);                    // R1
        AST_TOP_SIGN_SRC:   assert (!trits[4] || (trits[5] == code[4]));     // R2
        AST_LOW_SIGN_SRC:   assert (!trits[0] || (trits[1] == code[2]));     // R2
        AST_ALL_SET:        assert (code[1:0] != 2'b11 || (trits[4] && trits[2] && trits[0])); // R3
        AST_TOP_ZERO:       assert (code[1:0] != 2'b00 || (trits[5:4] == 2'b00 && trits[2] && trits[0] == code[4])); // R4
        AST_MID_ZERO:       assert (code[1:0] != 2'b10 || (trits[3:2] == 2'b00 && trits[0] && trits[4] == code[3])); // R5
        AST_LOW_ZERO:       assert (code[1:0] != 2'b01 || (trits[1:0] == 2'b00 && trits[2] == code[2] && trits[4] == (code[3] | code[2]))); // R6
    end
endmodule

// File: rtl/tern_word_expand.sv
// Module: expands a packed word of 5-bit codes into 6-bit digit triples.
// Assumes the memory word is LANES*5 bits; lane k sits at bits [5k+4:5k].
module tern_word_expand
    import tw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [CODE_W*LANES-1:0] code_i,
    output logic [TRIT_W*LANES-1:0] trit_o
);
    localparam int IN_W  = CODE_W * LANES;
    localparam int OUT_W = TRIT_W * LANES;

    // Purpose: elaboration-time check that the lane count is usable.
    initial begin
        AST_LANES_VALID: assert (LANES >= 1 && IN_W > 0 && OUT_W > 0);      // R8
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tw_lane u_lane (
            .code  (code_i[CODE_W*k +: CODE_W]),
            .trits (trit_o[TRIT_W*k +: TRIT_W])
        );
    end
endmodule

// File: tb/tern_word_expand_bench.sv
module tern_word_expand_bench;
    localparam int LANES = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [5*LANES-1:0]   code_i;
    logic [6*LANES-1:0]   trit_o;
    int                   checks = 0;
    int                   fails  = 0;
    int                   hits [27];
    bit                   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tern_word_expand #(.LANES(LANES)) u_tern_word_expand (
        .code_i (code_i),
        .trit_o (trit_o)
    );

    // Behavioural model: signed value of digit pos (2 = top) for a code.
    function automatic int model_digit(int code, int pos);
        int b [5];
        int top, mid, low;
        for (int i = 0; i < 5; i++) b[i] = (code >> i) & 1;
        if (b[1] == 1 && b[0] == 1) begin top = 1; mid = 1; low = 1; end        // R3
        else if (b[1] == 0 && b[0] == 0) begin top = 0; mid = 1; low = b[4]; end // R4
        else if (b[1] == 1) begin top = b[3]; mid = 0; low = 1; end             // R5
        else begin top = (b[3] + b[2] > 0) ? 1 : 0; mid = b[2]; low = 0; end    // R6
        if (b[4] == 1) top = -top;                                              // R2
        if (b[3] == 1) mid = -mid;
        if (b[2] == 1) low = -low;
        return (pos == 2) ? top : (pos == 1) ? mid : low;
    endfunction

    function automatic logic [1:0] enc(int v);
        if (v < 0) return 2'b11;
        if (v > 0) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [5:0] model_lane(int code);
        return {enc(model_digit(code, 2)), enc(model_digit(code, 1)), enc(model_digit(code, 0))};
    endfunction

    function automatic string tag_for(int code);
        case (code & 3)
            3: return "R3";
            0: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_int(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        code_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: code 00000 decodes to 000100 in every lane (R4).
        for (int k = 0; k < LANES; k++)
            check("R4 reset", trit_o[6*k +: 6], 6'b000100);
        rst_n = 1'b1;

        for (int c = 0; c < 32; c++) begin
            @(posedge clk);
            for (int k = 0; k < LANES; k++)
                code_i[5*k +: 5] = 5'((c + 7 * k) % 32);
            @(negedge clk);
            for (int k = 0; k < LANES; k++) begin
                automatic int cd = (c + 7 * k) % 32;
                automatic logic [5:0] got = trit_o[6*k +: 6];
                if (k == 0) check(tag_for(cd), got, model_lane(cd));
                else        check("R8 lane", got, model_lane(cd));
                for (int j = 0; j < 3; j++)
                    check_int("R1 pair", (got[2*j +: 2] == 2'b10) ? 1 : 0, 0);
                if (k == 0) begin
                    automatic int idx = (model_digit(cd, 2) + 1) * 9 +
                                        (model_digit(cd, 1) + 1) * 3 +
                                        (model_digit(cd, 0) + 1);
                    if (got == model_lane(cd)) hits[idx]++;
                end
            end
        end

        // Reachability and duplicate count (R7).
        begin
            automatic int distinct = 0;
            automatic int dups = 0;
            for (int i = 0; i < 27; i++) begin
                if (hits[i] > 0)  distinct++;
                if (hits[i] == 2) dups++;
            end
            check_int("R7 distinct", distinct, 27);
            check_int("R7 dups", dups, 5);
        end

        // Same-cycle response: change input mid-cycle and sample at once (R9).
        @(posedge clk);
        #1 code_i[4:0] = 5'b11110;
        #1 check("R9", trit_o[5:0], 6'b110011);
        code_i[4:0] = 5'b00101;
        #1 check("R9", trit_o[5:0], 6'b010100);
        // Sign gating on a zero top digit under group 00 (R2).
        code_i[4:0] = 5'b10000;
        #1 check("R2", trit_o[5:0], 6'b000101);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule